// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block follows a chain of transmit descriptors held in system memory and streams the bytes of each packet out one byte at a time. A descriptor is an array of 16-bit entries. Entry 0 receives a status word once the packet has been sent. Entries 1 to 3 hold a configuration word, the packet size and the number of fragments. Each fragment then takes a triplet of entries: pointer low half, pointer high half, byte count. The triplet of fragment i begins at entry 4 + 3·i. The entry that follows the last triplet is the link word. Its bit 0 flags the end of the chain, and the remaining bits give the low half of the next descriptor's address.

Software provides the low half of the first descriptor's address, the upper address half shared by every descriptor in the chain, the entry width mode and a transmit control word, and then pulses `start`. The walker fetches the header and copies each fragment through a simple request/acknowledge memory port. The bytes of one packet are capped at a buffer capacity. After each packet the walker writes the status word and then either follows the link or stops. It stops when the end-of-chain flag is set, and then pulses `irq`. It also stops, without reading the link, when `halt` is high as the packet completes.

Top module: `txw_walker`

## Requirements
- R1: After reset `busy`, `mem_req`, `out_valid` and `irq` are all low.
- R2: The descriptor base is `{upper_hi, start_lo}` with bit 0 forced to zero. Entry k lives at base + 2·k when `wide` is 0 and at base + 4·k when `wide` is 1. `wide` and `upper_hi` are captured at `start`.
- R3: For each descriptor the walker first reads entries 1, 2, 3, 4, 5, 6 in that order: configuration, packet size, fragment count, first fragment pointer low, pointer high, size.
- R4: Fragment i (i ≥ 1) is fetched from entries 4+3i, 5+3i, 6+3i just before its data is copied. When the fragment count is 0, no data is read.
- R5: Fragment bytes are read one per request, with `mem_byte` high, at pointer + offset in ascending order. Each byte read appears once on `out_data` with `out_valid`, one cycle after its acknowledge, fragment after fragment.
- R6: At most BUF_BYTES bytes are sent per packet. Bytes beyond that are neither read nor sent. The count restarts with every descriptor.
- R7: After the data of a packet, one write (`mem_we` high) places `tx_ctrl & 16'h0FFF` in entry 0.
- R8: The link word is read from entry 4 + 3·(fragment count). If its bit 0 is 1, `irq` pulses for one cycle and the walker goes idle. Otherwise the link value with bit 0 cleared becomes the next descriptor's low address.
- R9: If `halt` is high when the status write is acknowledged, the walker goes idle without reading the link and without raising `irq`.
- R10: A request keeps `mem_req`, `mem_addr` and `mem_we` unchanged until `mem_ack`.
- R11: A `start` pulse while `busy` is high has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (accepted only when idle) |
| start_lo | input | 16 | Low half of the first descriptor address |
| upper_hi | input | 16 | Upper address half for all descriptors |
| wide | input | 1 | 1: 32-bit entry spacing, 0: 16-bit |
| halt | input | 1 | Stop after the current packet |
| tx_ctrl | input | 16 | Transmit control word; low 12 bits form the status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a 16-bit write |
| mem_byte | output | 1 | Request is a byte read (data in `mem_rdata[7:0]`) |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 16 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| busy | output | 1 | Walk in progress |
| irq | output | 1 | One-cycle end-of-chain pulse |

## Verification
A wrong entry index or fragment base shows at the memory port on the next request: the address of that request is off, or a whole triplet lands at the wrong offset. The bench compares the logged address sequence entry by entry. A stale byte counter shows within one packet: too many bytes appear, or too few in the packet after a capped one. A wrong link decision shows within a few cycles of the status write, as a missing or extra `irq`, a link read that should not occur, or reads that wander into a descriptor never queued.

// File: rtl/txw_pkg.sv
`timescale 1ns/1ps
package txw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_FRAG,
      ST_COPY,
      ST_STAT,
      ST_LINK
   } walk_st_e;

   localparam logic [15:0] STAT_MASK = 16'h0FFF;
   localparam logic [15:0] LINK_EOL  = 16'h0001;
   localparam int          HDR_LAST  = 6;
   localparam int          TRIP_BASE = 4;
   localparam int          TRIP_LEN  = 3;
endpackage

// File: rtl/txw_addr.sv
`timescale 1ns/1ps
module txw_addr #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 19,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wide,
   output logic [ADDR_W-1:0] ent_addr
);
   generate
      if (ADDR_W < IDX_W + 2) begin : g_bad_width
         $error("txw_addr: ADDR_W too small for IDX_W");
      end
   endgenerate

   logic [ADDR_W-1:0] idx_ext;
   assign idx_ext = ADDR_W'(idx);

   generate
      if (ALLOW_WIDE) begin : g_dual
         assign ent_addr = base + (wide ? (idx_ext << 2) : (idx_ext << 1));
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide;
         assign ent_addr    = base + (idx_ext << 1);
      end
   endgenerate
endmodule

// File: rtl/txw_cap.sv
`timescale 1ns/1ps
module txw_cap #(
   parameter int BUF_BYTES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic take,
   output logic room
);
   localparam int CNT_W = $clog2(BUF_BYTES + 1);

   generate
      if (BUF_BYTES < 1) begin : g_bad_cap
         $error("txw_cap: BUF_BYTES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (take)  cnt <= cnt + 1'b1;
   end

   assign room = (cnt < CNT_W'(BUF_BYTES));

   // R6: a byte is only taken while the packet still has room
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> room);
   // R6: the count restarts with each descriptor
   a_r6_clr_room: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> room);
endmodule

// File: rtl/txw_walker.sv
`timescale 1ns/1ps
module txw_walker
   import txw_pkg::*;
#(
   parameter int HALF_W     = 16,
   parameter int BUF_BYTES  = 16,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       start_lo,
   input  logic [15:0]       upper_hi,
   input  logic              wide,
   input  logic              halt,
   input  logic [15:0]       tx_ctrl,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_byte,
   output logic [31:0]       mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [15:0]       mem_rdata,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              busy,
   output logic              irq
);
   localparam int ADDR_W = 2 * HALF_W;
   localparam int IDX_W  = HALF_W + 3;

   generate
      if (HALF_W != 16) begin : g_bad_half
         $error("txw_walker: port widths assume HALF_W == 16");
      end
   endgenerate

   walk_st_e          st;
   logic [HALF_W-1:0] desc_lo, desc_hi;
   logic              wide_q;
   logic [IDX_W-1:0]  ent_idx, frag_base, ent_sel;
   logic [1:0]        sub;
   logic [HALF_W-1:0] frag_cnt, frag_i, fsize, boff;
   logic [ADDR_W-1:0] fptr, ent_addr;
   logic              room, copy_go, copy_end, take, cap_clr;

   always_comb begin
      unique case (st)
         ST_STAT: ent_sel = '0;
         ST_LINK: ent_sel = frag_base;
         default: ent_sel = ent_idx;
      endcase
   end

   txw_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALLOW_WIDE(ALLOW_WIDE)) u_addr (
      .base     ({desc_hi, desc_lo}),
      .idx      (ent_sel),
      .wide     (wide_q),
      .ent_addr (ent_addr)
   );

   assign copy_go  = (st == ST_COPY) && (boff != fsize) && room;
   assign copy_end = (st == ST_COPY) && !((boff != fsize) && room);
   assign take     = copy_go && mem_ack;
   assign cap_clr  = ((st == ST_IDLE) && start) ||
                     ((st == ST_LINK) && mem_ack && !mem_rdata[0]);

   txw_cap #(.BUF_BYTES(BUF_BYTES)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cap_clr),
      .take  (take),
      .room  (room)
   );

   assign mem_req   = (st == ST_HDR) || (st == ST_FRAG) || (st == ST_STAT) ||
                      (st == ST_LINK) || copy_go;
   assign mem_we    = (st == ST_STAT);
   assign mem_byte  = (st == ST_COPY);
   assign mem_addr  = (st == ST_COPY) ? (fptr + ADDR_W'(boff)) : ent_addr;
   assign mem_wdata = tx_ctrl & STAT_MASK;
   assign busy      = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         desc_lo   <= '0;
         desc_hi   <= '0;
         wide_q    <= 1'b0;
         ent_idx   <= '0;
         frag_base <= '0;
         sub       <= '0;
         frag_cnt  <= '0;
         frag_i    <= '0;
         fsize     <= '0;
         boff      <= '0;
         fptr      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         irq       <= 1'b0;
      end else begin
         irq       <= 1'b0;
         out_valid <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  desc_lo   <= start_lo & ~LINK_EOL;
                  desc_hi   <= upper_hi;
                  wide_q    <= wide;
                  ent_idx   <= IDX_W'(1);
                  frag_base <= IDX_W'(TRIP_BASE);
                  frag_i    <= '0;
                  st        <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (mem_ack) begin
                  case (ent_idx)
                     IDX_W'(3): frag_cnt          <= mem_rdata;
                     IDX_W'(4): fptr[HALF_W-1:0]  <= mem_rdata;
                     IDX_W'(5): fptr[ADDR_W-1:HALF_W] <= mem_rdata;
                     IDX_W'(6): begin
                        fsize <= mem_rdata;
                        boff  <= '0;
                     end
                     default: ;
                  endcase
                  ent_idx <= ent_idx + 1'b1;
                  if (ent_idx == IDX_W'(HDR_LAST))
                     st <= (frag_cnt == '0) ? ST_STAT : ST_COPY;
               end
            end
            ST_FRAG: begin
               if (mem_ack) begin
                  case (sub)
                     2'd0:    fptr[HALF_W-1:0]      <= mem_rdata;
                     2'd1:    fptr[ADDR_W-1:HALF_W] <= mem_rdata;
                     default: begin
                        fsize <= mem_rdata;
                        boff  <= '0;
                     end
                  endcase
                  sub     <= sub + 1'b1;
                  ent_idx <= ent_idx + 1'b1;
                  if (sub == 2'd2) st <= ST_COPY;
               end
            end
            ST_COPY: begin
               if (copy_end) begin
                  frag_i    <= frag_i + 1'b1;
                  frag_base <= frag_base + IDX_W'(TRIP_LEN);
                  ent_idx   <= frag_base + IDX_W'(TRIP_LEN);
                  sub       <= '0;
                  st        <= ((frag_i + 1'b1) == frag_cnt) ? ST_STAT : ST_FRAG;
               end else if (mem_ack) begin
                  boff      <= boff + 1'b1;
                  out_valid <= 1'b1;
                  out_data  <= mem_rdata[7:0];
               end
            end
            ST_STAT: begin
               if (mem_ack) st <= halt ? ST_IDLE : ST_LINK;
            end
            ST_LINK: begin
               if (mem_ack) begin
                  desc_lo <= mem_rdata & ~LINK_EOL;
                  if (mem_rdata[0]) begin
                     irq <= 1'b1;
                     st  <= ST_IDLE;
                  end else begin
                     ent_idx   <= IDX_W'(1);
                     frag_base <= IDX_W'(TRIP_BASE);
                     frag_i    <= '0;
                     st        <= ST_HDR;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R10: an outstanding request is held until acknowledged
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   // R5: every output byte follows an acknowledged byte read
   a_r5_out_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(mem_ack && mem_byte));
   // R8: end-of-chain pulse lasts one cycle and leaves the walker idle
   a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy);
   // R9: halt at the status write ends the walk
   a_r9_halt_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack && halt) |=> (!busy && !irq));
   // R7: status write is a word access, never a byte access
   a_r7_word_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_req && !mem_byte));
endmodule

// File: tb/txw_walker_bench.sv
`timescale 1ns/1ps
module txw_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] start_lo = '0, upper_hi = '0, tx_ctrl = '0;
   logic        wide = 1'b0, halt = 1'b0;
   logic        mem_req, mem_we, mem_byte, out_valid, busy, irq;
   logic [31:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic [7:0]  out_data;

   always #2.5 clk = ~clk;

   txw_walker u_txw_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .start_lo(start_lo),
      .upper_hi(upper_hi), .wide(wide), .halt(halt), .tx_ctrl(tx_ctrl),
      .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
      .busy(busy), .irq(irq)
   );

   logic [7:0]  mem [0:4095];
   logic [32:0] lg  [0:511];
   logic [7:0]  ob  [0:511];
   int          lg_n = 0, ob_n = 0, irq_n = 0, hold_err = 0;
   logic [31:0] lat_a = '0;
   int          n_chk = 0, n_fail = 0;

   // memory model: accept a request, acknowledge it one cycle later
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         if (mem_ack && (!mem_req || mem_addr != lat_a)) hold_err++;
         if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            lat_a   <= mem_addr;
            lg[lg_n[8:0]] <= {mem_we, mem_addr};
            lg_n++;
            if (mem_we) begin
               mem[mem_addr[11:0]]        <= mem_wdata[7:0];
               mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
            end
            mem_rdata <= mem_byte ? {8'h00, mem[mem_addr[11:0]]}
                                  : {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
         end else begin
            mem_ack <= 1'b0;
         end
         if (out_valid) begin
            ob[ob_n[8:0]] <= out_data;
            ob_n++;
         end
         if (irq) irq_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic put16(input int a, input logic [15:0] v);
      mem[a[11:0]]         = v[7:0];
      mem[a[11:0] + 12'd1] = v[15:8];
   endtask

   function automatic logic [15:0] get16(input int a);
      return {mem[a[11:0] + 12'd1], mem[a[11:0]]};
   endfunction

   task automatic put_ent(input int base, input bit w, input int idx, input logic [15:0] v);
      int a = base + idx * (w ? 4 : 2);
      put16(a, v);
      if (w) put16(a + 2, 16'h0000);
   endtask

   function automatic logic [7:0] pat(input int a);
      return a[7:0] ^ 8'h5A;
   endfunction

   task automatic fill(input int a, input int len);
      for (int i = 0; i < len; i++) mem[(a + i) & 12'hFFF] = pat(a + i);
   endtask

   function automatic bit log_has(input int from, input logic [31:0] a);
      for (int i = from; i < lg_n; i++) if (lg[i[8:0]][31:0] == a) return 1'b1;
      return 1'b0;
   endfunction

   task automatic pulse_start(input logic [15:0] lo, input logic [15:0] hi,
                              input bit w, input logic [15:0] ctrl, input bit hlt);
      @(negedge clk);
      start_lo = lo; upper_hi = hi; wide = w; tx_ctrl = ctrl; halt = hlt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      chk(!busy, req, "walk finished", busy, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic test_reset();
      chk(!busy,      "R1", "busy after reset",      busy, 0);
      chk(!mem_req,   "R1", "mem_req after reset",   mem_req, 0);
      chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
      chk(!irq,       "R1", "irq after reset",       irq, 0);
   endtask

   // narrow entries, two fragments, end of chain
   task automatic test_narrow_two_frag();
      int lb = lg_n, bb = ob_n, ib = irq_n, bad = 0;
      logic [32:0] ex [0:16];
      put16(16'h100, 16'hFFFF);
      put_ent(16'h100, 0, 1, 16'h1234);
      put_ent(16'h100, 0, 2, 16'd5);
      put_ent(16'h100, 0, 3, 16'd2);
      put_ent(16'h100, 0, 4, 16'h0400);
      put_ent(16'h100, 0, 5, 16'h00A5);
      put_ent(16'h100, 0, 6, 16'd3);
      put_ent(16'h100, 0, 7, 16'h0410);
      put_ent(16'h100, 0, 8, 16'h00A5);
      put_ent(16'h100, 0, 9, 16'd2);
      put_ent(16'h100, 0, 10, 16'h0001);
      fill(16'h400, 3); fill(16'h410, 2);
      for (int k = 0; k < 6; k++) ex[k] = {1'b0, 32'h00A5_0102 + 32'(2 * k)};
      ex[6]  = {1'b0, 32'h00A5_0400}; ex[7] = {1'b0, 32'h00A5_0401};
      ex[8]  = {1'b0, 32'h00A5_0402};
      ex[9]  = {1'b0, 32'h00A5_010E}; ex[10] = {1'b0, 32'h00A5_0110};
      ex[11] = {1'b0, 32'h00A5_0112};
      ex[12] = {1'b0, 32'h00A5_0410}; ex[13] = {1'b0, 32'h00A5_0411};
      ex[14] = {1'b1, 32'h00A5_0100};
      ex[15] = {1'b0, 32'h00A5_0114};
      pulse_start(16'h0100, 16'h00A5, 1'b0, 16'hF3C5, 1'b0);
      wait_idle("R8");
      chk(lg_n - lb == 16, "R3", "request count", lg_n - lb, 16);
      for (int k = 0; k < 6; k++)  if (lg[(lb + k) & 511] != ex[k]) bad++;
      chk(bad == 0, "R3", "header read order", bad, 0);
      bad = 0;
      for (int k = 9; k < 12; k++) if (lg[(lb + k) & 511] != ex[k]) bad++;
      chk(bad == 0, "R4", "second triplet addresses", bad, 0);
      bad = 0;
      for (int k = 0; k < 16; k++) if (lg[(lb + k) & 511] != ex[k]) bad++;
      chk(bad == 0, "R2", "narrow entry addresses with upper half", bad, 0);
      chk(lg[(lb + 15) & 511] == ex[15], "R8", "link read at entry 10",
          lg[(lb + 15) & 511], ex[15]);
      chk(ob_n - bb == 5, "R5", "byte count", ob_n - bb, 5);
      bad = 0;
      for (int k = 0; k < 3; k++) if (ob[(bb + k) & 511] != pat(16'h400 + k)) bad++;
      for (int k = 0; k < 2; k++) if (ob[(bb + 3 + k) & 511] != pat(16'h410 + k)) bad++;
      chk(bad == 0, "R5", "byte order and content", bad, 0);
      chk(get16(16'h100) == 16'h03C5, "R7", "status word", get16(16'h100), 16'h03C5);
      chk(irq_n - ib == 1, "R8", "irq pulses at end of chain", irq_n - ib, 1);
   endtask

   // wide entries, two chained descriptors, start address with bit 0 set
   task automatic test_wide_chain();
      int lb = lg_n, bb = ob_n, ib = irq_n, bad = 0;
      put16(16'h200, 16'hFFFF); put16(16'h300, 16'hFFFF);
      put_ent(16'h200, 1, 1, 16'h0); put_ent(16'h200, 1, 2, 16'd3);
      put_ent(16'h200, 1, 3, 16'd1); put_ent(16'h200, 1, 4, 16'h0500);
      put_ent(16'h200, 1, 5, 16'h0);  put_ent(16'h200, 1, 6, 16'd3);
      put_ent(16'h200, 1, 7, 16'h0300);
      put_ent(16'h300, 1, 1, 16'h0); put_ent(16'h300, 1, 2, 16'd2);
      put_ent(16'h300, 1, 3, 16'd1); put_ent(16'h300, 1, 4, 16'h0520);
      put_ent(16'h300, 1, 5, 16'h0);  put_ent(16'h300, 1, 6, 16'd2);
      put_ent(16'h300, 1, 7, 16'h0301);
      fill(16'h500, 3); fill(16'h520, 2);
      pulse_start(16'h0201, 16'h0000, 1'b1, 16'hABCD, 1'b0);
      wait_idle("R8");
      chk(lg[lb & 511] == {1'b0, 32'h0000_0204}, "R2", "wide first header entry",
          lg[lb & 511], {1'b0, 32'h0000_0204});
      chk(log_has(lb, 32'h0000_021C), "R8", "link of first descriptor read", 0, 1);
      chk(log_has(lb, 32'h0000_031C), "R8", "link followed to second descriptor", 0, 1);
      chk(ob_n - bb == 5, "R5", "bytes over two packets", ob_n - bb, 5);
      for (int k = 0; k < 3; k++) if (ob[(bb + k) & 511] != pat(16'h500 + k)) bad++;
      for (int k = 0; k < 2; k++) if (ob[(bb + 3 + k) & 511] != pat(16'h520 + k)) bad++;
      chk(bad == 0, "R5", "bytes of chained packets", bad, 0);
      chk(get16(16'h200) == 16'h0BCD, "R7", "status first descriptor", get16(16'h200), 16'h0BCD);
      chk(get16(16'h300) == 16'h0BCD, "R7", "status second descriptor", get16(16'h300), 16'h0BCD);
      chk(irq_n - ib == 1, "R8", "single irq for chain", irq_n - ib, 1);
   endtask

   // capacity cap: 12 + 8 bytes sent as 16, then a fresh packet of 3
   task automatic test_truncate();
      int lb = lg_n, bb = ob_n, bad = 0;
      put_ent(16'h600, 0, 1, 16'h0); put_ent(16'h600, 0, 2, 16'd20);
      put_ent(16'h600, 0, 3, 16'd2); put_ent(16'h600, 0, 4, 16'h0700);
      put_ent(16'h600, 0, 5, 16'h0);  put_ent(16'h600, 0, 6, 16'd12);
      put_ent(16'h600, 0, 7, 16'h0710); put_ent(16'h600, 0, 8, 16'h0);
      put_ent(16'h600, 0, 9, 16'd8);  put_ent(16'h600, 0, 10, 16'h0680);
      put_ent(16'h680, 0, 1, 16'h0); put_ent(16'h680, 0, 2, 16'd3);
      put_ent(16'h680, 0, 3, 16'd1); put_ent(16'h680, 0, 4, 16'h0740);
      put_ent(16'h680, 0, 5, 16'h0);  put_ent(16'h680, 0, 6, 16'd3);
      put_ent(16'h680, 0, 7, 16'h0001);
      fill(16'h700, 12); fill(16'h710, 8); fill(16'h740, 3);
      pulse_start(16'h0600, 16'h0000, 1'b0, 16'h0055, 1'b0);
      wait_idle("R6");
      chk(ob_n - bb == 19, "R6", "bytes with cap then fresh packet", ob_n - bb, 19);
      for (int k = 0; k < 12; k++) if (ob[(bb + k) & 511] != pat(16'h700 + k)) bad++;
      for (int k = 0; k < 4; k++)  if (ob[(bb + 12 + k) & 511] != pat(16'h710 + k)) bad++;
      for (int k = 0; k < 3; k++)  if (ob[(bb + 16 + k) & 511] != pat(16'h740 + k)) bad++;
      chk(bad == 0, "R6", "truncated content", bad, 0);
      chk(!log_has(lb, 32'h0000_0714), "R6", "byte past capacity not read", 1, 0);
   endtask

   // halt at end of packet: no link read, no irq
   task automatic test_halt();
      int lb = lg_n, bb = ob_n, ib = irq_n;
      put16(16'h800, 16'hFFFF);
      put_ent(16'h800, 0, 1, 16'h0); put_ent(16'h800, 0, 2, 16'd2);
      put_ent(16'h800, 0, 3, 16'd1); put_ent(16'h800, 0, 4, 16'h0900);
      put_ent(16'h800, 0, 5, 16'h0);  put_ent(16'h800, 0, 6, 16'd2);
      put_ent(16'h800, 0, 7, 16'h0880);
      fill(16'h900, 2);
      pulse_start(16'h0800, 16'h0000, 1'b0, 16'h7123, 1'b1);
      wait_idle("R9");
      halt = 1'b0;
      chk(ob_n - bb == 2, "R9", "packet still sent", ob_n - bb, 2);
      chk(get16(16'h800) == 16'h0123, "R9", "status written before halt", get16(16'h800), 16'h0123);
      chk(!log_has(lb, 32'h0000_080E), "R9", "link not read", 1, 0);
      chk(!log_has(lb, 32'h0000_0882), "R9", "next descriptor untouched", 1, 0);
      chk(irq_n - ib == 0, "R9", "no irq on halt", irq_n - ib, 0);
   endtask

   // second start while busy is ignored
   task automatic test_start_busy();
      int lb = lg_n, bb = ob_n, ib = irq_n, bad = 0;
      put_ent(16'hA00, 0, 1, 16'h0); put_ent(16'hA00, 0, 2, 16'd4);
      put_ent(16'hA00, 0, 3, 16'd1); put_ent(16'hA00, 0, 4, 16'h0B00);
      put_ent(16'hA00, 0, 5, 16'h0);  put_ent(16'hA00, 0, 6, 16'd4);
      put_ent(16'hA00, 0, 7, 16'h0001);
      fill(16'hB00, 4);
      pulse_start(16'h0A00, 16'h0000, 1'b0, 16'h0001, 1'b0);
      repeat (6) @(negedge clk);
      start_lo = 16'h0C00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle("R11");
      chk(ob_n - bb == 4, "R11", "byte count unchanged", ob_n - bb, 4);
      for (int k = 0; k < 4; k++) if (ob[(bb + k) & 511] != pat(16'hB00 + k)) bad++;
      chk(bad == 0, "R11", "bytes unchanged", bad, 0);
      chk(!log_has(lb, 32'h0000_0C02), "R11", "second descriptor not fetched", 1, 0);
      chk(irq_n - ib == 1, "R11", "one irq", irq_n - ib, 1);
   endtask

   // zero fragments: no data, link at entry 4
   task automatic test_zero_frag();
      int lb = lg_n, bb = ob_n;
      put16(16'hD00, 16'hFFFF);
      put_ent(16'hD00, 0, 1, 16'h0); put_ent(16'hD00, 0, 2, 16'd0);
      put_ent(16'hD00, 0, 3, 16'd0); put_ent(16'hD00, 0, 4, 16'h0001);
      put_ent(16'hD00, 0, 5, 16'h0);  put_ent(16'hD00, 0, 6, 16'd7);
      pulse_start(16'h0D00, 16'h0000, 1'b0, 16'h0F0F, 1'b0);
      wait_idle("R4");
      chk(ob_n - bb == 0, "R4", "no bytes for empty descriptor", ob_n - bb, 0);
      chk(lg[(lb + 7) & 511] == {1'b0, 32'h0000_0D08}, "R4", "link read at entry 4",
          lg[(lb + 7) & 511], {1'b0, 32'h0000_0D08});
      chk(get16(16'hD00) == 16'h0F0F, "R7", "status for empty descriptor", get16(16'hD00), 16'h0F0F);
   endtask

   initial begin
      #(5.0 * 180000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_narrow_two_frag();
      test_wide_chain();
      test_truncate();
      test_halt();
      test_start_busy();
      test_zero_frag();
      chk(hold_err == 0, "R10", "request held until ack", hold_err, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule